// File: doc/BRIEF.md
# Instruction Miss Sample Capture Register

This block records one instruction-side miss event at a time so that sampling software can read it later. A configuration register holds a mode bit and a 4-bit mask field, and the mode bit decides how the mask field is read. In cache mode (mode = 0), the field is a latency threshold. An instruction cache miss is recorded only when its reported latency is strictly above that threshold. Both its instruction address and its latency are latched.

In TLB mode (mode = 1), the same field is a filter on the miss type. Each instruction TLB miss arrives with a one-hot 4-bit type code. The miss is recorded only when the code shares at least one set bit with the mask. Only its address is kept, and the latency register reads zero.

A recorded sample raises a valid flag. The flag locks the address and latency registers until software writes a clear. A global enable input stops all capture while it is low.

Top module: `imiss_sample_reg`

## Requirements
- R1: After a synchronous reset, the valid flag, the address, the latency, the mode readback and the mask readback are all zero.
- R2: In cache mode (mode bit 0), a cache miss strobe with latency greater than the mask value sets valid one clock later. On that same edge the address and latency registers are loaded with the strobe's values.
- R3: In cache mode, a cache miss whose latency is less than or equal to the mask value is not recorded. The boundary case is equal latency.
- R4: In TLB mode (mode bit 1), a TLB miss whose type code ANDed with the mask is non-zero sets valid one clock later. On that edge its address is loaded and the latency register is loaded with zero.
- R5: In TLB mode, a TLB miss whose type code ANDed with the mask is zero is not recorded.
- R6: The strobe that does not belong to the current mode has no effect. Cache mode ignores TLB strobes, and TLB mode ignores cache strobes.
- R7: While valid is 1, all captures are blocked. A clear write while valid is 1 returns valid to 0 one clock later, and the held address and latency stay unchanged.
- R8: While the enable input is low, nothing is captured and the held address and latency stay unchanged.
- R9: A configuration write becomes visible on the readback and takes effect on the next clock. A miss in the same cycle as the write is judged under the previous configuration.
- R10: Address and latency change only on the edge where valid rises, and they change together on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_en | input | 1 | Global capture enable |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_tlb_mode | input | 1 | Mode to write (1 = TLB, 0 = cache) |
| cfg_mask | input | MASK_W | Mask/threshold to write |
| flag_clr | input | 1 | Software clear of the valid flag |
| ic_miss_vld | input | 1 | Cache miss strobe |
| ic_miss_addr | input | ADDR_W | Cache miss instruction address |
| ic_miss_lat | input | LAT_W | Cache miss latency |
| tlb_miss_vld | input | 1 | TLB miss strobe |
| tlb_miss_addr | input | ADDR_W | TLB miss instruction address |
| tlb_miss_type | input | MASK_W | One-hot TLB miss type code |
| mode_q | output | 1 | Current mode readback |
| mask_q | output | MASK_W | Current mask readback |
| smp_valid | output | 1 | Sample held flag |
| smp_addr | output | ADDR_W | Held address |
| smp_lat | output | LAT_W | Held latency (zero for TLB samples) |

## Verification
The assertions assume that every input is driven to a known value on every clock after reset. They also assume that the TLB type code is one-hot or zero whenever its strobe is high. Nothing is assumed about how the two miss strobes relate, and the properties must hold even when both are high together.

The stimulus changes inputs only on the falling edge. It uses only one-hot type codes, and its latency values stay within the latency width. It also covers simultaneous strobes, clears and configuration writes.

// File: rtl/imiss_pkg.sv
package imiss_pkg;
  typedef enum logic {
    MODE_CACHE = 1'b0,
    MODE_TLB   = 1'b1
  } cap_mode_e;
endpackage

// File: rtl/imiss_cfg_reg.sv
module imiss_cfg_reg #(
  parameter int MASK_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                we,
  input  logic                mode_in,
  input  logic [MASK_W-1:0]   mask_in,
  output imiss_pkg::cap_mode_e mode,
  output logic [MASK_W-1:0]   mask
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode <= imiss_pkg::MODE_CACHE;
      mask <= '0;
    end else if (we) begin
      mode <= imiss_pkg::cap_mode_e'(mode_in);
      mask <= mask_in;
    end
  end
endmodule

// File: rtl/imiss_qualify.sv
module imiss_qualify #(
  parameter int ADDR_W = 32,
  parameter int LAT_W  = 12,
  parameter int MASK_W = 4
) (
  input  imiss_pkg::cap_mode_e mode,
  input  logic [MASK_W-1:0]    mask,
  input  logic                 ic_vld,
  input  logic [ADDR_W-1:0]    ic_addr,
  input  logic [LAT_W-1:0]     ic_lat,
  input  logic                 tlb_vld,
  input  logic [ADDR_W-1:0]    tlb_addr,
  input  logic [MASK_W-1:0]    tlb_type,
  output logic                 hit,
  output logic [ADDR_W-1:0]    hit_addr,
  output logic [LAT_W-1:0]     hit_lat
);
  logic [MASK_W-1:0] type_match;
  logic              ic_hit;
  logic              tlb_hit;

  for (genvar b = 0; b < MASK_W; b++) begin : g_type
    assign type_match[b] = tlb_type[b] & mask[b];
  end

  assign ic_hit  = ic_vld && (ic_lat > LAT_W'(mask));
  assign tlb_hit = tlb_vld && (|type_match);

  always_comb begin
    if (mode == imiss_pkg::MODE_TLB) begin
      hit      = tlb_hit;
      hit_addr = tlb_addr;
      hit_lat  = '0;
    end else begin
      hit      = ic_hit;
      hit_addr = ic_addr;
      hit_lat  = ic_lat;
    end
  end
endmodule

// File: rtl/imiss_hold.sv
module imiss_hold #(
  parameter int ADDR_W = 32,
  parameter int LAT_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              clr,
  input  logic              hit,
  input  logic [ADDR_W-1:0] hit_addr,
  input  logic [LAT_W-1:0]  hit_lat,
  output logic              valid,
  output logic [ADDR_W-1:0] addr,
  output logic [LAT_W-1:0]  lat
);
  logic take;
  assign take = en && hit && !valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      addr  <= '0;
      lat   <= '0;
    end else begin
      if (take) begin
        valid <= 1'b1;
        addr  <= hit_addr;
        lat   <= hit_lat;
      end else if (clr) begin
        valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/imiss_sample_reg.sv
module imiss_sample_reg #(
  parameter int ADDR_W = 32,
  parameter int LAT_W  = 12,
  parameter int MASK_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap_en,
  input  logic              cfg_we,
  input  logic              cfg_tlb_mode,
  input  logic [MASK_W-1:0] cfg_mask,
  input  logic              flag_clr,
  input  logic              ic_miss_vld,
  input  logic [ADDR_W-1:0] ic_miss_addr,
  input  logic [LAT_W-1:0]  ic_miss_lat,
  input  logic              tlb_miss_vld,
  input  logic [ADDR_W-1:0] tlb_miss_addr,
  input  logic [MASK_W-1:0] tlb_miss_type,
  output logic              mode_q,
  output logic [MASK_W-1:0] mask_q,
  output logic              smp_valid,
  output logic [ADDR_W-1:0] smp_addr,
  output logic [LAT_W-1:0]  smp_lat
);
  imiss_pkg::cap_mode_e mode_r;
  logic                 hit;
  logic [ADDR_W-1:0]    hit_addr;
  logic [LAT_W-1:0]     hit_lat;

  imiss_cfg_reg #(.MASK_W(MASK_W)) i_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .mode_in(cfg_tlb_mode),
    .mask_in(cfg_mask), .mode(mode_r), .mask(mask_q)
  );

  assign mode_q = (mode_r == imiss_pkg::MODE_TLB);

  imiss_qualify #(.ADDR_W(ADDR_W), .LAT_W(LAT_W), .MASK_W(MASK_W)) i_qual (
    .mode(mode_r), .mask(mask_q),
    .ic_vld(ic_miss_vld), .ic_addr(ic_miss_addr), .ic_lat(ic_miss_lat),
    .tlb_vld(tlb_miss_vld), .tlb_addr(tlb_miss_addr), .tlb_type(tlb_miss_type),
    .hit(hit), .hit_addr(hit_addr), .hit_lat(hit_lat)
  );

  imiss_hold #(.ADDR_W(ADDR_W), .LAT_W(LAT_W)) i_hold (
    .clk(clk), .rst(rst), .en(cap_en), .clr(flag_clr), .hit(hit),
    .hit_addr(hit_addr), .hit_lat(hit_lat),
    .valid(smp_valid), .addr(smp_addr), .lat(smp_lat)
  );
endmodule

// File: rtl/imiss_sample_chk.sv
module imiss_sample_chk #(
  parameter int ADDR_W = 32,
  parameter int LAT_W  = 12,
  parameter int MASK_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              cap_en,
  input logic              flag_clr,
  input logic              ic_miss_vld,
  input logic              tlb_miss_vld,
  input logic [MASK_W-1:0] tlb_miss_type,
  input logic              mode_q,
  input logic [MASK_W-1:0] mask_q,
  input logic              smp_valid,
  input logic [ADDR_W-1:0] smp_addr,
  input logic [LAT_W-1:0]  smp_lat
);
  AST_CAP_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    $rose(smp_valid) |-> $past(cap_en)); // R8
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
    !$rose(smp_valid) |-> ($stable(smp_addr) && $stable(smp_lat))); // R10
  AST_CACHE_ABOVE_THRESH: assert property (@(posedge clk) disable iff (rst)
    ($rose(smp_valid) && !$past(mode_q)) |-> (smp_lat > LAT_W'($past(mask_q)))); // R3
  AST_CACHE_SRC: assert property (@(posedge clk) disable iff (rst)
    ($rose(smp_valid) && !$past(mode_q)) |-> $past(ic_miss_vld)); // R6
  AST_TLB_LAT_ZERO: assert property (@(posedge clk) disable iff (rst)
    ($rose(smp_valid) && $past(mode_q)) |-> (smp_lat == '0)); // R4
  AST_TLB_TYPE_MATCH: assert property (@(posedge clk) disable iff (rst)
    ($rose(smp_valid) && $past(mode_q)) |->
      ($past(tlb_miss_vld) && (($past(tlb_miss_type) & $past(mask_q)) != '0))); // R5
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && flag_clr) |=> !smp_valid); // R7
endmodule

bind imiss_sample_reg imiss_sample_chk #(
  .ADDR_W(ADDR_W), .LAT_W(LAT_W), .MASK_W(MASK_W)
) i_chk (
  .clk(clk), .rst(rst), .cap_en(cap_en), .flag_clr(flag_clr),
  .ic_miss_vld(ic_miss_vld), .tlb_miss_vld(tlb_miss_vld),
  .tlb_miss_type(tlb_miss_type), .mode_q(mode_q), .mask_q(mask_q),
  .smp_valid(smp_valid), .smp_addr(smp_addr), .smp_lat(smp_lat)
);

// File: tb/test_imiss_sample_reg.sv
module test_imiss_sample_reg;
  localparam int ADDR_W = 32;
  localparam int LAT_W  = 12;
  localparam int MASK_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cap_en = 1'b0, cfg_we = 1'b0, cfg_tlb_mode = 1'b0, flag_clr = 1'b0;
  logic [MASK_W-1:0] cfg_mask = '0, tlb_miss_type = '0;
  logic ic_miss_vld = 1'b0, tlb_miss_vld = 1'b0;
  logic [ADDR_W-1:0] ic_miss_addr = '0, tlb_miss_addr = '0;
  logic [LAT_W-1:0] ic_miss_lat = '0;
  logic mode_q, smp_valid;
  logic [MASK_W-1:0] mask_q;
  logic [ADDR_W-1:0] smp_addr;
  logic [LAT_W-1:0] smp_lat;

  always #2 clk = ~clk;

  imiss_sample_reg #(.ADDR_W(ADDR_W), .LAT_W(LAT_W), .MASK_W(MASK_W)) i_imiss_sample_reg (
    .clk(clk), .rst(rst), .cap_en(cap_en), .cfg_we(cfg_we),
    .cfg_tlb_mode(cfg_tlb_mode), .cfg_mask(cfg_mask), .flag_clr(flag_clr),
    .ic_miss_vld(ic_miss_vld), .ic_miss_addr(ic_miss_addr), .ic_miss_lat(ic_miss_lat),
    .tlb_miss_vld(tlb_miss_vld), .tlb_miss_addr(tlb_miss_addr),
    .tlb_miss_type(tlb_miss_type), .mode_q(mode_q), .mask_q(mask_q),
    .smp_valid(smp_valid), .smp_addr(smp_addr), .smp_lat(smp_lat)
  );

  typedef struct {
    logic              valid;
    logic [ADDR_W-1:0] addr;
    logic [LAT_W-1:0]  lat;
    logic              mode;
    logic [MASK_W-1:0] mask;
    string             req;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic              m_valid = 1'b0, m_mode = 1'b0;
  logic [ADDR_W-1:0] m_addr = '0;
  logic [LAT_W-1:0]  m_lat = '0;
  logic [MASK_W-1:0] m_mask = '0;

  task automatic compare(input exp_t e);
    checks++;
    if (smp_valid !== e.valid || smp_addr !== e.addr || smp_lat !== e.lat ||
        mode_q !== e.mode || mask_q !== e.mask) begin
      failures++;
      $display("FAIL %s: got v=%0b a=%h l=%0d m=%0b k=%h exp v=%0b a=%h l=%0d m=%0b k=%h",
               e.req, smp_valid, smp_addr, smp_lat, mode_q, mask_q,
               e.valid, e.addr, e.lat, e.mode, e.mask);
    end
  endtask

  // Driver: applies one cycle of stimulus and pushes the expected result
  task automatic step(input logic en, input logic we, input logic md,
                      input logic [MASK_W-1:0] mk, input logic clr,
                      input logic icv, input logic [ADDR_W-1:0] ica,
                      input logic [LAT_W-1:0] icl, input logic tv,
                      input logic [ADDR_W-1:0] ta, input logic [MASK_W-1:0] tt,
                      input string req);
    logic cap;
    exp_t e;
    @(negedge clk);
    cap_en = en; cfg_we = we; cfg_tlb_mode = md; cfg_mask = mk; flag_clr = clr;
    ic_miss_vld = icv; ic_miss_addr = ica; ic_miss_lat = icl;
    tlb_miss_vld = tv; tlb_miss_addr = ta; tlb_miss_type = tt;
    cap = en && !m_valid &&
          (m_mode ? (tv && ((tt & m_mask) != '0))
                  : (icv && (icl > LAT_W'(m_mask))));
    if (cap) begin
      m_valid = 1'b1; m_addr = m_mode ? ta : ica; m_lat = m_mode ? '0 : icl;
    end else if (clr) begin
      m_valid = 1'b0;
    end
    if (we) begin m_mode = md; m_mask = mk; end
    e.valid = m_valid; e.addr = m_addr; e.lat = m_lat;
    e.mode = m_mode; e.mask = m_mask; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic idle(input string req);
    step(1'b1, 1'b0, 1'b0, '0, 1'b0, 1'b0, '0, '0, 1'b0, '0, '0, req);
  endtask

  // Monitor: compares each result just after the edge that produced it
  initial begin
    forever begin
      @(posedge clk); #1;
      if (exp_q.size() > 0) compare(exp_q.pop_front());
    end
  end

  initial begin
    exp_t z;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    z.valid = 0; z.addr = '0; z.lat = '0; z.mode = 0; z.mask = '0; z.req = "R1";
    compare(z);
    // R9: write mask 5 while a latency-3 miss arrives; old threshold 0 applies
    step(1, 1, 0, 4'd5, 0, 1, 32'hA000_0010, 12'd3, 0, '0, '0, "R9");
    step(1, 0, 0, '0, 1, 0, '0, '0, 0, '0, '0, "R7");
    // R3: equal latency is not recorded
    step(1, 0, 0, '0, 0, 1, 32'hA000_0020, 12'd5, 0, '0, '0, "R3");
    // R2: latency above threshold
    step(1, 0, 0, '0, 0, 1, 32'hA000_0030, 12'd6, 0, '0, '0, "R2");
    // R7: blocked while valid, then clear keeps held pair
    step(1, 0, 0, '0, 0, 1, 32'hA000_0040, 12'd15, 0, '0, '0, "R7");
    step(1, 0, 0, '0, 1, 1, 32'hA000_0050, 12'd15, 0, '0, '0, "R7");
    // R8: enable low
    step(0, 0, 0, '0, 0, 1, 32'hA000_0060, 12'd99, 0, '0, '0, "R8");
    idle("R8");
    // R6: cache mode ignores TLB strobe
    step(1, 0, 0, '0, 0, 0, '0, '0, 1, 32'hB000_0010, 4'b0001, "R6");
    // Both strobes: cache one wins in cache mode (R10 pair)
    step(1, 0, 0, '0, 0, 1, 32'hA000_0070, 12'd200, 1, 32'hB000_0020, 4'b0100, "R10");
    step(1, 0, 0, '0, 1, 0, '0, '0, 0, '0, '0, "R7");
    // Switch to TLB mode with filter 0110
    step(1, 1, 1, 4'b0110, 0, 0, '0, '0, 0, '0, '0, "R9");
    step(1, 0, 0, '0, 0, 0, '0, '0, 1, 32'hB000_0030, 4'b0001, "R5");
    step(1, 0, 0, '0, 0, 0, '0, '0, 1, 32'hB000_0040, 4'b1000, "R5");
    step(1, 0, 0, '0, 0, 1, 32'hA000_0080, 12'd300, 0, '0, '0, "R6");
    step(1, 0, 0, '0, 0, 0, '0, '0, 1, 32'hB000_0050, 4'b0100, "R4");
    step(1, 0, 0, '0, 1, 0, '0, '0, 1, 32'hB000_0060, 4'b0010, "R7");
    step(1, 0, 0, '0, 0, 1, 32'hA000_0090, 12'd400, 1, 32'hB000_0070, 4'b0010, "R4");
    idle("R10");
    idle("R10");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule